// File: doc/BRIEF.md
# Tree Pseudo-LRU Way Selector

This block holds the replacement state of a 4-way set-associative cache. Each set keeps a three-bit binary tree. A root bit chooses between the way pair {A,B} and the way pair {C,D}. A left bit chooses between A and B, and a right bit chooses between C and D. A bit value of 1 records that the left side of its node was used most recently. A value of 0 records that the right side was used most recently. The ways are encoded A=0, B=1, C=2 and D=3 on every way port.

The cache controller reports each access by driving the set, the way and a valid strobe. The tree of that set takes its new value at the next rising clock edge. A fill into a victim way is reported in the same way as any other access. A separate query port takes a set index and returns the way to replace next. The returned way is decoded combinationally from the stored bits of that set, so a query always sees the tree as it was before an update to the same set in the same cycle. Tag storage, hit detection and the eviction datapath lie outside this block.

The block has no sequencing state machine. Its only state is one tree per set. Each tree has four decode regions, one for each possible victim: A when root=0 and left=0, B when root=0 and left=1, C when root=1 and right=0, and D when root=1 and right=1. An access moves the tree between these regions.

Top module: `plru_way_sel`

## Requirements
- R1: After reset every set holds root=0, left=0 and right=0, so a query of any set returns way A (0).
- R2: An access to way A (0) sets root=1 and left=1 in that set and leaves right unchanged.
- R3: An access to way B (1) sets root=1 and left=0 in that set and leaves right unchanged.
- R4: An access to way C (2) sets root=0 and right=1 in that set and leaves left unchanged.
- R5: An access to way D (3) sets root=0 and right=0 in that set and leaves left unchanged.
- R6: The query port returns A (0) when root=0 and left=0, B (1) when root=0 and left=1, C (2) when root=1 and right=0, and D (3) when root=1 and right=1.
- R7: An access changes only the tree of the set it names. The trees of all other sets keep their values.
- R8: While acc_valid is low, no tree changes, whatever values acc_set and acc_way hold.
- R9: When an access and a query name the same set in one cycle, victim_way reflects the tree from before that access. The update shows up on victim_way from the next cycle on.
- R10: A fill into the reported victim way updates the tree exactly as an access to that way does. Four back-to-back fills into one set, starting from reset, therefore pick A, C, B and D in turn and then return to A.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| acc_valid | input | 1 | An access or fill is reported this cycle |
| acc_set | input | SET_W | Set index of the access |
| acc_way | input | 2 | Way that was accessed (A=0, B=1, C=2, D=3) |
| qry_set | input | SET_W | Set index of the victim query |
| victim_way | output | 2 | Way to replace in the queried set |

## Verification
The bench goes after the cases where a design would mix up the tree's nodes. An update that touched the bit of the sibling pair, or one that inverted the meaning of 1 and 0, would send the victim sequence after a run of fills along the wrong path instead of the A, C, B, D cycle. It also checks accesses with the valid strobe low, and accesses to one set while a neighbouring set is queried. A write enable or a set decode that leaked would change the victim of a set that was never touched. Same-cycle access and query of one set are checked as well. Here a forwarding path, or an update taken on the wrong edge, would show the new victim one cycle early.

// File: rtl/plru_pkg.sv
package plru_pkg;

    typedef enum logic [1:0] {
        WAY_A = 2'd0,
        WAY_B = 2'd1,
        WAY_C = 2'd2,
        WAY_D = 2'd3
    } way_e;

    // One replacement tree; 1 = left side of the node was used last.
    typedef struct packed {
        logic cd_side;   // C (1) versus D (0)
        logic ab_side;   // A (1) versus B (0)
        logic root;      // pair AB (1) versus pair CD (0)
    } tree_t;

    localparam tree_t TREE_RESET = '{cd_side: 1'b0, ab_side: 1'b0, root: 1'b0};

endpackage

// File: rtl/plru_tree_update.sv
module plru_tree_update
    import plru_pkg::*;
(
    input  tree_t cur_tree,
    input  way_e  used_way,
    output tree_t nxt_tree
);

    always_comb begin
        nxt_tree = cur_tree;
        unique case (used_way)
            WAY_A: begin
                nxt_tree.root    = 1'b1;
                nxt_tree.ab_side = 1'b1;
            end
            WAY_B: begin
                nxt_tree.root    = 1'b1;
                nxt_tree.ab_side = 1'b0;
            end
            WAY_C: begin
                nxt_tree.root    = 1'b0;
                nxt_tree.cd_side = 1'b1;
            end
            WAY_D: begin
                nxt_tree.root    = 1'b0;
                nxt_tree.cd_side = 1'b0;
            end
            default: nxt_tree = cur_tree;
        endcase
    end

endmodule

// File: rtl/plru_victim_pick.sv
module plru_victim_pick
    import plru_pkg::*;
(
    input  tree_t tree,
    output way_e  victim
);

    always_comb begin
        unique case ({tree.root, tree.root ? tree.cd_side : tree.ab_side})
            2'b00:   victim = WAY_A;
            2'b01:   victim = WAY_B;
            2'b10:   victim = WAY_C;
            2'b11:   victim = WAY_D;
            default: victim = WAY_A;
        endcase
    end

endmodule

// File: rtl/plru_tree_bank.sv
module plru_tree_bank
    import plru_pkg::*;
#(
    parameter int NUM_SETS = 16,
    localparam int SET_W   = (NUM_SETS > 1) ? $clog2(NUM_SETS) : 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [SET_W-1:0] wr_set,
    input  tree_t            wr_tree,
    input  logic [SET_W-1:0] rd_a_set,
    output tree_t            rd_a_tree,
    input  logic [SET_W-1:0] rd_b_set,
    output tree_t            rd_b_tree
);

    tree_t [NUM_SETS-1:0] tree_q;

    for (genvar s = 0; s < NUM_SETS; s++) begin : g_set
        logic set_we;
        assign set_we = wr_en && (wr_set == SET_W'(s));

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                tree_q[s] <= TREE_RESET;
            end else if (set_we) begin
                tree_q[s] <= wr_tree;
            end
        end

        // R7 R8
        untouched_set_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
            !(wr_en && wr_set == SET_W'(s)) |=> $stable(tree_q[s]));
    end

    assign rd_a_tree = tree_q[rd_a_set];
    assign rd_b_tree = tree_q[rd_b_set];

endmodule

// File: rtl/plru_way_sel.sv
module plru_way_sel
    import plru_pkg::*;
#(
    parameter int NUM_SETS = 16,
    localparam int SET_W   = (NUM_SETS > 1) ? $clog2(NUM_SETS) : 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             acc_valid,
    input  logic [SET_W-1:0] acc_set,
    input  logic [1:0]       acc_way,
    input  logic [SET_W-1:0] qry_set,
    output logic [1:0]       victim_way
);

    tree_t acc_cur;
    tree_t acc_nxt;
    tree_t qry_tree;
    way_e  victim_e;
    way_e  acc_way_e;

    assign acc_way_e = way_e'(acc_way);

    plru_tree_bank #(.NUM_SETS(NUM_SETS)) u_bank (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_en     (acc_valid),
        .wr_set    (acc_set),
        .wr_tree   (acc_nxt),
        .rd_a_set  (acc_set),
        .rd_a_tree (acc_cur),
        .rd_b_set  (qry_set),
        .rd_b_tree (qry_tree)
    );

    plru_tree_update u_update (
        .cur_tree (acc_cur),
        .used_way (acc_way_e),
        .nxt_tree (acc_nxt)
    );

    plru_victim_pick u_pick (
        .tree   (qry_tree),
        .victim (victim_e)
    );

    assign victim_way = victim_e;

    // R2
    access_a_update_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_valid && acc_way == 2'd0) |=>
            (u_bank.tree_q[$past(acc_set)].root == 1'b1) &&
            (u_bank.tree_q[$past(acc_set)].ab_side == 1'b1) &&
            (u_bank.tree_q[$past(acc_set)].cd_side == $past(acc_cur.cd_side)));

    // R3
    access_b_update_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_valid && acc_way == 2'd1) |=>
            (u_bank.tree_q[$past(acc_set)].root == 1'b1) &&
            (u_bank.tree_q[$past(acc_set)].ab_side == 1'b0) &&
            (u_bank.tree_q[$past(acc_set)].cd_side == $past(acc_cur.cd_side)));

    // R4
    access_c_update_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_valid && acc_way == 2'd2) |=>
            (u_bank.tree_q[$past(acc_set)].root == 1'b0) &&
            (u_bank.tree_q[$past(acc_set)].cd_side == 1'b1) &&
            (u_bank.tree_q[$past(acc_set)].ab_side == $past(acc_cur.ab_side)));

    // R5
    access_d_update_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_valid && acc_way == 2'd3) |=>
            (u_bank.tree_q[$past(acc_set)].root == 1'b0) &&
            (u_bank.tree_q[$past(acc_set)].cd_side == 1'b0) &&
            (u_bank.tree_q[$past(acc_set)].ab_side == $past(acc_cur.ab_side)));

    // R6
    victim_left_pair_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !qry_tree.root |-> (victim_way == {1'b0, qry_tree.ab_side}));

    // R6
    victim_right_pair_chk: assert property (@(posedge clk) disable iff (!rst_n)
        qry_tree.root |-> (victim_way == {1'b1, qry_tree.cd_side}));

endmodule

// File: tb/tb_plru_way_sel.sv
module tb_plru_way_sel;

    localparam int NSETS = 16;
    localparam int SW    = $clog2(NSETS);

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          acc_valid = 1'b0;
    logic [SW-1:0] acc_set = '0;
    logic [1:0]    acc_way = '0;
    logic [SW-1:0] qry_set = '0;
    logic [1:0]    victim_way;

    int checks = 0;
    int fails  = 0;

    bit m_root [NSETS];
    bit m_left [NSETS];
    bit m_right[NSETS];

    always #10 clk = ~clk;

    plru_way_sel #(.NUM_SETS(NSETS)) dut (
        .clk        (clk),
        .rst_n      (rst_n),
        .acc_valid  (acc_valid),
        .acc_set    (acc_set),
        .acc_way    (acc_way),
        .qry_set    (qry_set),
        .victim_way (victim_way)
    );

    function automatic int model_victim(int s);
        if (m_root[s] == 0) return m_left[s] ? 1 : 0;
        return m_right[s] ? 3 : 2;
    endfunction

    function automatic void model_access(int s, int w);
        case (w)
            0: begin m_root[s] = 1; m_left[s]  = 1; end
            1: begin m_root[s] = 1; m_left[s]  = 0; end
            2: begin m_root[s] = 0; m_right[s] = 1; end
            default: begin m_root[s] = 0; m_right[s] = 0; end
        endcase
    endfunction

    task automatic check_victim(string req, int exp);
        checks++;
        if (int'(victim_way) != exp) begin
            fails++;
            $display("FAIL %s: set %0d victim %0d expected %0d", req, qry_set, victim_way, exp);
        end
    endtask

    // One cycle: drive after the falling edge, compare before the rising edge.
    task automatic cyc(string req, bit v, int s, int w, int q);
        acc_valid = v;
        acc_set   = SW'(s);
        acc_way   = 2'(w);
        qry_set   = SW'(q);
        #3;
        check_victim(req, model_victim(q));
        @(posedge clk);
        if (v) model_access(s, w);
        @(negedge clk);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        fails++;
        $display("FAIL watchdog: run did not complete, actual hung expected done");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        for (int i = 0; i < NSETS; i++) begin
            m_root[i] = 0; m_left[i] = 0; m_right[i] = 0;
        end
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1: every set picks A after reset
        for (int i = 0; i < NSETS; i++) begin
            qry_set = SW'(i);
            #2;
            check_victim("R1", 0);
        end

        // R2 then R4 then R3 then R5 on set 3, observed through the victim
        cyc("R2", 1, 3, 0, 3);
        cyc("R2", 0, 3, 0, 3);
        check_victim("R2", 2);
        cyc("R4", 1, 3, 2, 3);
        cyc("R4", 0, 3, 0, 3);
        check_victim("R4", 1);
        cyc("R3", 1, 3, 1, 3);
        cyc("R3", 0, 3, 0, 3);
        check_victim("R3", 3);
        cyc("R5", 1, 3, 3, 3);
        cyc("R5", 0, 3, 0, 3);
        check_victim("R5", 0);

        // R6: walk set 5 through all four victim regions
        cyc("R6", 1, 5, 2, 5);
        cyc("R6", 1, 5, 1, 5);
        cyc("R6", 1, 5, 3, 5);
        cyc("R6", 1, 5, 0, 5);
        cyc("R6", 0, 5, 0, 5);

        // R8: strobe low with busy address lines
        cyc("R8", 0, 7, 0, 7);
        cyc("R8", 0, 7, 2, 7);
        cyc("R8", 0, 7, 3, 7);
        check_victim("R8", 0);

        // R7: accesses to set 8 leave set 9 at A
        cyc("R7", 1, 8, 0, 9);
        cyc("R7", 1, 8, 3, 9);
        cyc("R7", 0, 8, 0, 9);
        check_victim("R7", 0);

        // R9: same-set access and query; victim shows the old tree
        cyc("R9", 1, 10, 0, 10);
        cyc("R9", 0, 10, 0, 10);
        check_victim("R9", 2);

        // R10: fills into the reported victim of set 12 cycle A,C,B,D,A
        for (int k = 0; k < 5; k++) begin
            int exp_seq;
            qry_set = SW'(12);
            #2;
            case (k)
                0: exp_seq = 0;
                1: exp_seq = 2;
                2: exp_seq = 1;
                3: exp_seq = 3;
                default: exp_seq = 0;
            endcase
            check_victim("R10", exp_seq);
            cyc("R10", 1, 12, int'(victim_way), 12);
        end

        // R7 R8 R9: mixed traffic against the model
        for (int n = 0; n < 400; n++) begin
            int s = int'($urandom_range(NSETS - 1));
            int q = ($urandom_range(3) == 0) ? s : int'($urandom_range(NSETS - 1));
            cyc("R7", bit'($urandom_range(1)), s, int'($urandom_range(3)), q);
        end

        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule